// File: doc/BRIEF.md
# MII Management Controller

This block is a register-mapped master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software programs a target PHY address and register number. It then either writes a 16-bit value to a control register, which sends a write frame, or moves a command bit from 0 to 1, which sends a read frame. Each frame follows the classic 32-bit-address-space management format. The block builds it from a preamble, start code, opcode, both address fields, a turnaround and 16 data bits, and shifts it out on an internally divided MDC clock.

Progress is reported through an indicator register. A busy flag covers the whole frame. A separate invalid flag marks a read whose result has not yet landed in the status register. A soft-reset bit in the configuration register aborts any frame in flight and holds the serial engine idle. The MDC divide ratio is chosen by a 3-bit code in the same register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the indicator, configuration and status registers read 0, MDC is low and the MDIO output enable is low.
- R2: Registers sit at byte offsets 0x20 (config: bit 31 soft reset, bits 2:0 divider code), 0x24 (command: bit 0 read request), 0x28 (address: PHY in bits 12:8, register in bits 4:0), 0x2C (write data, bits 15:0), 0x30 (read result, bits 15:0) and 0x34 (indicators). Config and address read back what was written.
- R3: A write to 0x2C while idle sends a frame with the pin driven for all 64 bits: 32 ones, start 01, opcode 01, PHY address, register number (both MSB first), turnaround 10, then the written 16 bits MSB first.
- R4: A read frame carries opcode 10 and drives only its first 46 bits. It releases the pin for turnaround and data, samples 16 bits on rising MDC edges MSB first, and places them in bits 15:0 of 0x30 as busy clears.
- R5: A command write that leaves bit 0 at 1 when it was already 1 starts no frame.
- R6: Indicator bit 0 (busy) is 1 from the cycle after a frame is accepted until the frame's last MDC falling edge, and 0 otherwise.
- R7: Indicator bit 2 (invalid) is 1 while a read is in flight and drops when the read result is stored. A write frame never sets it.
- R8: A write to 0x2C or a read request made while busy is ignored: no frame results and the write-data register keeps its earlier value.
- R9: Divider codes 0 to 7 give MDC periods of 4, 6, 8, 10, 14, 20, 28 and 40 system clocks with equal high and low halves. MDC is low whenever no frame runs.
- R10: Setting config bit 31 aborts a running frame, clears busy and invalid, forces MDC low, releases MDIO, and blocks new frames until the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; data valid the following cycle |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
A new command can arrive in the same cycle as a frame that is still shifting. A bus write to the data register, or a read-request edge, can therefore coincide with a busy engine. The bench provokes this by issuing both kinds of command a few cycles into a write frame. It then judges the outcome at the pins: a PHY model must decode exactly one frame carrying the first data word, the data register must read back unchanged, and the indicators must stay clear afterwards. The soft-reset bit landing mid-frame is the second collision. It is judged by busy and invalid reading 0 at once with MDC held low, and by a fresh frame that follows running cleanly.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int SEL_W  = 3;
    localparam int HALF_W = 6;

    // register byte offsets (software-visible map)
    localparam logic [ADDR_W-1:0] OFF_CFG = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CMD = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_ADR = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_CTL = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_STS = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_IND = 8'h34;

    localparam int CFG_SOFT_BIT = 31;
    localparam int ADR_PHY_LSB  = 8;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e          op;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regn;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    // half of the MDC period, in system clocks, for each divider code
    function automatic logic [HALF_W-1:0] mdc_half(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 6'd2;
            3'd1:    return 6'd3;
            3'd2:    return 6'd4;
            3'd3:    return 6'd5;
            3'd4:    return 6'd7;
            3'd5:    return 6'd10;
            3'd6:    return 6'd14;
            default: return 6'd20;
        endcase
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam logic [HALF_W-1:0] H_ONE = HALF_W'(1);

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = mdc_half(sel);
    assign wrap = en && (cnt >= half - H_ONE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + H_ONE;
        end
    end

    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // R9: MDC only ever rises while a frame enables the divider
    assert_mdc_gated_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> $past(en));

    // R9: MDC holds its level between divider wraps
    assert_mdc_half_R9: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HDR_LEN   = 2 + 2 + PHY_W + REG_W;
    localparam int DRIVE_RD  = PREAMBLE_LEN + HDR_LEN;
    localparam int DATA_POS  = DRIVE_RD + 2;
    localparam int FRAME_LEN = DATA_POS + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);

    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] DRIVE_IDX = IDX_W'(DRIVE_RD);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(DATA_POS);
    localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

    logic                 busy_q;
    logic                 is_rd;
    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] frame_init;
    logic [IDX_W-1:0]     idx;
    logic [DATA_W-1:0]    cap;
    logic                 last;
    logic                 req_rd;

    assign req_rd = (req.op == OP_READ);
    assign frame_init = {{PREAMBLE_LEN{1'b1}}, 2'b01, req.op, req.phy, req.regn,
                         (req_rd ? 2'b11 : 2'b10),
                         (req_rd ? {DATA_W{1'b0}} : req.wdata)};
    assign last = (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            is_rd  <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
            cap    <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            is_rd  <= req_rd;
            shreg  <= frame_init;
            idx    <= '0;
            cap    <= '0;
        end else if (busy_q) begin
            if (rise_tick && is_rd && (idx >= DATA_IDX)) begin
                cap <= {cap[DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (last) begin
                    busy_q <= 1'b0;
                end else begin
                    idx   <= idx + IDX_ONE;
                    shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    assign busy    = busy_q;
    assign rd_done = busy_q && is_rd && fall_tick && last;
    assign rd_data = cap;
    assign mdio_o  = busy_q ? shreg[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = busy_q && (!is_rd || (idx < DRIVE_IDX));

    // R6: busy only rises after an accepted start
    assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(start));

    // R8: the register side never issues a start while a frame runs
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R3: the bit position advances only on MDC falling ticks
    assert_idx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !fall_tick) |=> $stable(idx));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_rd_done,
    input  logic [DATA_W-1:0] eng_rd_data,
    output logic              soft_rst,
    output logic [SEL_W-1:0]  div_sel,
    output logic              start,
    output mdio_req_t         req
);

    logic              cfg_soft;
    logic [SEL_W-1:0]  cfg_sel;
    logic              cmd_rd;
    logic [PHY_W-1:0]  adr_phy;
    logic [REG_W-1:0]  adr_reg;
    logic [DATA_W-1:0] ctl_data;
    logic [DATA_W-1:0] status;
    logic              invalid;
    logic [BUS_W-1:0]  rd_mux;

    logic wr_cfg, wr_cmd, wr_adr, wr_ctl;
    logic go_wr, go_rd;
    logic unused_wbits;

    assign unused_wbits = ^bus_wdata[CFG_SOFT_BIT-1:DATA_W];

    assign wr_cfg = bus_wr && (bus_addr == OFF_CFG);
    assign wr_cmd = bus_wr && (bus_addr == OFF_CMD);
    assign wr_adr = bus_wr && (bus_addr == OFF_ADR);
    assign wr_ctl = bus_wr && (bus_addr == OFF_CTL);

    // a write frame starts on a data write, a read on a 0->1 command edge
    assign go_wr = wr_ctl && !eng_busy && !cfg_soft;
    assign go_rd = wr_cmd && bus_wdata[0] && !cmd_rd && !eng_busy && !cfg_soft;
    assign start = go_wr || go_rd;

    always_comb begin
        req.op    = go_rd ? OP_READ : OP_WRITE;
        req.phy   = adr_phy;
        req.regn  = adr_reg;
        req.wdata = bus_wdata[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_soft <= 1'b0;
            cfg_sel  <= '0;
            cmd_rd   <= 1'b0;
            adr_phy  <= '0;
            adr_reg  <= '0;
            ctl_data <= '0;
            status   <= '0;
            invalid  <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_soft <= bus_wdata[CFG_SOFT_BIT];
                cfg_sel  <= bus_wdata[SEL_W-1:0];
            end
            if (wr_cmd) cmd_rd <= bus_wdata[0];
            if (wr_adr) begin
                adr_phy <= bus_wdata[ADR_PHY_LSB +: PHY_W];
                adr_reg <= bus_wdata[REG_W-1:0];
            end
            if (go_wr) ctl_data <= bus_wdata[DATA_W-1:0];
            if (eng_rd_done) status <= eng_rd_data;
            if (cfg_soft)         invalid <= 1'b0;
            else if (go_rd)       invalid <= 1'b1;
            else if (eng_rd_done) invalid <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CFG: rd_mux = {cfg_soft, {(BUS_W-1-SEL_W){1'b0}}, cfg_sel};
            OFF_CMD: rd_mux = {{(BUS_W-1){1'b0}}, cmd_rd};
            OFF_ADR: rd_mux = {{(BUS_W-ADR_PHY_LSB-PHY_W){1'b0}}, adr_phy,
                               {(ADR_PHY_LSB-REG_W){1'b0}}, adr_reg};
            OFF_CTL: rd_mux = {{(BUS_W-DATA_W){1'b0}}, ctl_data};
            OFF_STS: rd_mux = {{(BUS_W-DATA_W){1'b0}}, status};
            OFF_IND: rd_mux = {{(BUS_W-3){1'b0}}, invalid, 1'b0, eng_busy};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign soft_rst = cfg_soft;
    assign div_sel  = cfg_sel;

    // R7: invalid drops only when a read result lands or soft reset acts
    assert_inv_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(invalid) |-> ($past(eng_rd_done) || $past(cfg_soft)));

    // R4: the read result register changes only on read completion
    assert_status_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !eng_rd_done |=> $stable(status));

    // R8: a data write during a frame leaves the data register untouched
    assert_ctl_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && eng_busy) |=> $stable(ctl_data));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic              soft_rst;
    logic              eng_rst;
    logic [SEL_W-1:0]  div_sel;
    logic              start;
    mdio_req_t         req;
    logic              busy;
    logic              rd_done;
    logic [DATA_W-1:0] rd_data;
    logic              rise_tick;
    logic              fall_tick;

    assign eng_rst = rst || soft_rst;

    mdio_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .eng_busy    (busy),
        .eng_rd_done (rd_done),
        .eng_rd_data (rd_data),
        .soft_rst    (soft_rst),
        .div_sel     (div_sel),
        .start       (start),
        .req         (req)
    );

    mdio_clkgen u_clkgen (
        .clk       (clk),
        .rst       (eng_rst),
        .en        (busy),
        .sel       (div_sel),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame #(
        .PREAMBLE_LEN (PREAMBLE_LEN)
    ) u_frame (
        .clk       (clk),
        .rst       (eng_rst),
        .start     (start),
        .req       (req),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_done   (rd_done),
        .rd_data   (rd_data)
    );

    // R9: MDC rests low whenever the engine is idle
    assert_mdc_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R10: an active soft reset leaves the pin released
    assert_soft_release_R10: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) && soft_rst |-> !mdio_oe);

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   frames_seen = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_pattern(input logic [4:0] p, input logic [4:0] r);
        return {~r, p, 6'b100101};
    endfunction

    task automatic push_exp(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        exp_t e;
        e.op = op; e.phy = p; e.regn = r;
        e.data = (op == 2'b10) ? rd_pattern(p, r) : d;
        exp_q.push_back(e);
    endtask

    // ---------------- PHY model / monitor ----------------
    logic [63:0] fbits = '0;
    logic [63:0] foe = '0;
    int          bitcnt = 0;
    logic [1:0]  cur_op = '0;
    logic [4:0]  cur_phy = '0;
    logic [4:0]  cur_reg = '0;
    time         t_rise = 0;
    int          last_high = 0;

    task automatic judge_frame();
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected frame", fbits, 64'd0);
            return;
        end
        e = exp_q.pop_front();
        check(fbits[63:18] == {32'hFFFF_FFFF, 2'b01, e.op, e.phy, e.regn},
              "R3 frame header", fbits[63:18], {32'hFFFF_FFFF, 2'b01, e.op, e.phy, e.regn});
        if (e.op == 2'b01) begin
            check(fbits[17:0] == {2'b10, e.data}, "R3 write turnaround and data",
                  fbits[17:0], {2'b10, e.data});
            check(foe == {64{1'b1}}, "R3 write drives all bits", foe, {64{1'b1}});
        end else begin
            check(foe == {{46{1'b1}}, 18'd0}, "R4 read release window", foe, {{46{1'b1}}, 18'd0});
        end
    endtask

    always @(posedge mdc) begin
        t_rise = $time;
        fbits = {fbits[62:0], mdio_o};
        foe   = {foe[62:0], mdio_oe};
        bitcnt++;
        if (bitcnt == 36) cur_op  = fbits[1:0];
        if (bitcnt == 41) cur_phy = fbits[4:0];
        if (bitcnt == 46) cur_reg = fbits[4:0];
        if (bitcnt == 64) begin
            bitcnt = 0;
            frames_seen++;
            judge_frame();
            cur_op = '0;
        end
    end

    always @(negedge mdc) begin
        logic [15:0] pv;
        last_high = int'(($time - t_rise) / 10);
        if (cur_op == 2'b10 && bitcnt >= 48 && bitcnt < 64) begin
            pv = rd_pattern(cur_phy, cur_reg);
            mdio_i = pv[63 - bitcnt];
        end else begin
            mdio_i = 1'b1;
        end
    end

    // ---------------- bus driver ----------------
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            bus_read(8'h34, v);
            if (!v[0]) break;
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL R6 watchdog: actual running expected idle");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int expected_frames;
        expected_frames = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(8'h34, v); check(v == 0, "R1 indicators", v, 0);
        bus_read(8'h20, v); check(v == 0, "R1 config", v, 0);
        bus_read(8'h30, v); check(v == 0, "R1 status", v, 0);
        @(negedge clk);
        check(mdc == 0 && mdio_oe == 0, "R1 pins idle", {mdc, mdio_oe}, 0);

        // R2 config sequence and readback
        bus_write(8'h20, 32'h8000_0000);
        bus_write(8'h20, 32'h0000_0000);
        bus_read(8'h20, v); check(v == 32'h0, "R2 config readback", v, 0);
        bus_write(8'h28, 32'h0000_0511);
        bus_read(8'h28, v); check(v == 32'h0000_0511, "R2 address readback", v, 32'h511);

        // R3 write frame; R6/R7 indicators; R8 commands while busy
        push_exp(2'b01, 5'd5, 5'h11, 16'hBEEF); expected_frames++;
        bus_write(8'h2C, 32'h0000_BEEF);
        bus_read(8'h34, v); check(v == 32'h1, "R6 busy during write, R7 no invalid", v, 1);
        bus_write(8'h2C, 32'h0000_1234);
        bus_write(8'h24, 32'h1);
        bus_read(8'h2C, v); check(v == 32'hBEEF, "R8 data write ignored while busy", v, 32'hBEEF);
        wait_idle();
        repeat (20) @(negedge clk);
        bus_read(8'h34, v); check(v == 0, "R8 no read after busy command", v, 0);
        check(mdc == 0, "R9 MDC idle low", mdc, 0);

        // R4 read frame
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'h0000_1F02);
        push_exp(2'b10, 5'h1F, 5'h02, 16'h0); expected_frames++;
        bus_write(8'h24, 32'h1);
        bus_read(8'h34, v); check(v == 32'h5, "R7 busy and invalid during read", v, 5);
        wait_idle();
        bus_read(8'h30, v);
        check(v == {16'h0, rd_pattern(5'h1F, 5'h02)}, "R4 read result", v, rd_pattern(5'h1F, 5'h02));
        bus_read(8'h34, v); check(v == 0, "R7 invalid cleared after read", v, 0);

        // R5 command held at 1 starts nothing
        bus_write(8'h24, 32'h1);
        bus_read(8'h34, v); check(v == 0, "R5 no frame without edge", v, 0);

        // second read, other address
        bus_write(8'h24, 32'h0);
        bus_write(8'h28, 32'h0000_001F);
        push_exp(2'b10, 5'h00, 5'h1F, 16'h0); expected_frames++;
        bus_write(8'h24, 32'h1);
        wait_idle();
        bus_read(8'h30, v);
        check(v == {16'h0, rd_pattern(5'h00, 5'h1F)}, "R4 second read result", v, rd_pattern(5'h00, 5'h1F));

        // R9 divider codes
        bus_write(8'h20, 32'h3);
        bus_write(8'h28, 32'h0000_0A15);
        push_exp(2'b01, 5'h0A, 5'h15, 16'h0F0F); expected_frames++;
        bus_write(8'h2C, 32'h0000_0F0F);
        wait_idle();
        check(last_high == 5, "R9 code 3 high phase", last_high, 5);
        bus_write(8'h20, 32'h7);
        push_exp(2'b01, 5'h0A, 5'h15, 16'h8001); expected_frames++;
        bus_write(8'h2C, 32'h0000_8001);
        wait_idle();
        check(last_high == 20, "R9 code 7 high phase", last_high, 20);

        // R10 soft reset mid-frame
        bus_write(8'h20, 32'h0);
        push_exp(2'b01, 5'h0A, 5'h15, 16'h5555);
        bus_write(8'h2C, 32'h0000_5555);
        repeat (100) @(negedge clk);
        bus_write(8'h20, 32'h8000_0000);
        bus_read(8'h34, v); check(v == 0, "R10 abort clears indicators", v, 0);
        check(mdc == 0 && mdio_oe == 0, "R10 pins idle after abort", {mdc, mdio_oe}, 0);
        void'(exp_q.pop_back());
        bitcnt = 0; cur_op = '0;
        bus_write(8'h2C, 32'h0000_AAAA);
        bus_read(8'h34, v); check(v == 0, "R10 start blocked in soft reset", v, 0);
        bus_write(8'h20, 32'h0);
        push_exp(2'b01, 5'h0A, 5'h15, 16'hC3C3); expected_frames++;
        bus_write(8'h2C, 32'h0000_C3C3);
        wait_idle();
        repeat (10) @(negedge clk);

        check(exp_q.size() == 0 && frames_seen == expected_frames, "R8 frame count",
              frames_seen, expected_frames);

        finished = 1;
        summary();
        $finish;
    end

endmodule